// File: doc/BRIEF.md
# Coherent 24-bit register byte port

This block lets an 8-bit host bus read and write wide registers that internal logic also updates on any cycle, such as a commanded position or a running position count. Each protected register is split into byte lanes: lane 0 is the least significant byte, lane 1 the middle byte and lane 2 the most significant byte. The host must write the upper lanes first. They only fill holding registers. The write of lane 0 then loads the whole word into the live register in a single clock.

Reads follow the opposite order. A read of lane 0 returns the live low byte. In the same clock it freezes the live upper bytes into capture registers. Later reads of lane 1 and lane 2 return those frozen bytes, so the three bytes the host assembles always come from one instant, even if the live word has moved since.

Two register instances share the bus by default. The byte address is `{register index, lane}`, so register k lane b sits at address 4·k + b. Lane code 3 and register indices beyond the instance count are unmapped. The internal side loads each live register through its own load strobe and value, and the live words are always visible on an output.

Top module: `wreg_byte_port`

## Requirements
- R1: After reset every live word is 0, every holding and capture byte is 0, and `bus_rdata` is 0.
- R2: A host write to lane 1 or lane 2 of a register only updates that lane's holding byte. The live word of that register is unchanged after the write.
- R3: A host write to lane 0 of register k loads {held lane 2, held lane 1, written byte} into live word k on that clock edge. The holding bytes keep their values afterwards.
- R4: When a lane 0 write and an internal load strobe hit the same register on the same edge, the host word is stored and the internal value is dropped.
- R5: An internal load strobe with no host commit on that register replaces the live word with the internal value on that edge.
- R6: A host read of lane 0 returns, one cycle later on `bus_rdata`, the low byte of the live word as it stood at the read edge. On that same edge it captures the live lanes 1 and 2.
- R7: A host read of lane 1 or lane 2 returns the captured byte from the most recent lane 0 read of that register, even if the live word changed after the capture.
- R8: Reading lane 1 or lane 2 of a register whose lane 0 has not been read since reset returns 0.
- R9: The address is {register index, 2-bit lane}: register k lane b is byte address 4·k + b. An access to one register never changes the live, holding or capture state of another.
- R10: A read of an unmapped address (lane code 3, or a register index at or above the instance count) returns 0, and a write to such an address changes no live word.
- R11: `bus_rdata` holds its last value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Host byte write strobe |
| bus_rd | input | 1 | Host byte read strobe |
| bus_addr | input | ADDR_W (3) | Byte address {register index, lane} |
| bus_wdata | input | DATA_W (8) | Host write byte |
| bus_rdata | output | DATA_W (8) | Host read byte, registered, valid the cycle after the read strobe |
| upd_load | input | NUM_REGS (2) | Per-register internal load strobe |
| upd_value | input | NUM_REGS*WORD_W (48) | Internal load words, register k at bits 24k+23..24k |
| live_word | output | NUM_REGS*WORD_W (48) | Live register words, same packing as upd_value |

## Verification
Every result is due one clock edge after its stimulus. A lane 0 write or an internal load shows on `live_word` after the edge that samples it. A read byte shows on `bus_rdata` after the edge that samples the read strobe. A capture made by a lane 0 read is only seen through later lane 1 and lane 2 reads. The bench drives every strobe on a falling edge, holds it across one rising edge, and samples the outputs on the next falling edge, where the new value has settled and nothing else has yet moved. It keeps its own model of the live, holding and capture bytes and updates that model by the same one-edge rule.

// File: rtl/wreg_pkg.sv
package wreg_pkg;

   // bits needed to index n items, never less than one
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wreg_addr_dec.sv
module wreg_addr_dec #(
   parameter int unsigned NUM_REGS = 2,
   parameter int unsigned BYTES    = 3,
   parameter int unsigned REG_W    = 1,
   parameter int unsigned LANE_W   = 2
) (
   input  logic [REG_W+LANE_W-1:0]   addr,
   input  logic                      wr,
   input  logic                      rd,
   output logic [NUM_REGS*BYTES-1:0] wr_lane,
   output logic [NUM_REGS*BYTES-1:0] rd_lane,
   output logic                      hit
);

   logic [REG_W-1:0]  reg_idx;
   logic [LANE_W-1:0] lane;

   assign reg_idx = addr[REG_W+LANE_W-1:LANE_W];
   assign lane    = addr[LANE_W-1:0];
   assign hit     = (int'(reg_idx) < int'(NUM_REGS)) && (int'(lane) < int'(BYTES));

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar b = 0; b < BYTES; b++) begin : g_lane
         logic sel;
         assign sel = (reg_idx == REG_W'(r)) && (lane == LANE_W'(b));
         assign wr_lane[r*BYTES+b] = wr & sel;
         assign rd_lane[r*BYTES+b] = rd & sel;
      end
   end

endmodule

// File: rtl/wreg_coherent.sv
module wreg_coherent #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned BYTES  = 3,
   localparam int unsigned WORD_W = DATA_W * BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTES-1:0]  wr_lane,
   input  logic [BYTES-1:0]  rd_lane,
   input  logic [DATA_W-1:0] wdata,
   input  logic              int_load,
   input  logic [WORD_W-1:0] int_value,
   output logic [WORD_W-1:0] live,
   output logic [DATA_W-1:0] rd_byte
);

   localparam int unsigned UP_W = WORD_W - DATA_W;

   logic [WORD_W-1:0] live_q;
   logic [UP_W-1:0]   hold_q;
   logic [UP_W-1:0]   cap_q;
   logic              commit;

   assign commit = wr_lane[0];
   assign live   = live_q;

   // upper lane holding bytes, filled by host writes to lanes 1..BYTES-1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else begin
         for (int b = 1; b < int'(BYTES); b++) begin
            if (wr_lane[b]) hold_q[(b-1)*DATA_W +: DATA_W] <= wdata;
         end
      end
   end

   // live word: host commit first, internal load second
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        live_q <= '0;
      else if (commit)   live_q <= {hold_q, wdata};
      else if (int_load) live_q <= int_value;
   end

   // snapshot of the upper lanes taken by a low lane read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q <= '0;
      else if (rd_lane[0]) cap_q <= live_q[WORD_W-1:DATA_W];
   end

   always_comb begin
      rd_byte = '0;
      if (rd_lane[0]) rd_byte = live_q[DATA_W-1:0];
      for (int b = 1; b < int'(BYTES); b++) begin
         if (rd_lane[b]) rd_byte = rd_byte | cap_q[(b-1)*DATA_W +: DATA_W];
      end
   end

   assert_upper_wr_keeps_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !int_load) |=> $stable(live_q));

   assert_commit_low_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> live_q[DATA_W-1:0] == $past(wdata));

   assert_host_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && int_load) |=> live_q[WORD_W-1:DATA_W] == $past(hold_q));

   assert_internal_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_load && !commit) |=> live_q == $past(int_value));

   assert_capture_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lane[0] |=> cap_q == $past(live_q[WORD_W-1:DATA_W]));

   assert_capture_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lane[0] |=> $stable(cap_q));

   assert_one_read_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> $onehot0(rd_lane));

endmodule

// File: rtl/wreg_rd_mux.sv
module wreg_rd_mux #(
   parameter int unsigned NUM_REGS = 2,
   parameter int unsigned DATA_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd,
   input  logic [NUM_REGS*DATA_W-1:0]   rd_bytes,
   output logic [DATA_W-1:0]            rdata
);

   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] rdata_q;

   // unselected registers drive zero, so an OR tree is the mux
   always_comb begin
      merged = '0;
      for (int r = 0; r < int'(NUM_REGS); r++) begin
         merged = merged | rd_bytes[r*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= merged;
   end

   assign rdata = rdata_q;

   assert_rdata_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata_q));

endmodule

// File: rtl/wreg_byte_port.sv
module wreg_byte_port #(
   parameter int unsigned NUM_REGS = 2,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned BYTES    = 3,
   localparam int unsigned WORD_W  = DATA_W * BYTES,
   localparam int unsigned REG_W   = wreg_pkg::idx_w(NUM_REGS),
   localparam int unsigned LANE_W  = wreg_pkg::idx_w(BYTES),
   localparam int unsigned ADDR_W  = REG_W + LANE_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [NUM_REGS-1:0]        upd_load,
   input  logic [NUM_REGS*WORD_W-1:0] upd_value,
   output logic [NUM_REGS*WORD_W-1:0] live_word
);

   if (BYTES < 2) begin : g_chk_bytes
      $error("wreg_byte_port: BYTES must be at least 2");
   end
   if (NUM_REGS < 1) begin : g_chk_regs
      $error("wreg_byte_port: NUM_REGS must be at least 1");
   end
   if (DATA_W < 1) begin : g_chk_width
      $error("wreg_byte_port: DATA_W must be at least 1");
   end

   logic [NUM_REGS*BYTES-1:0]  wr_lane;
   logic [NUM_REGS*BYTES-1:0]  rd_lane;
   logic [NUM_REGS*DATA_W-1:0] rd_bytes;
   logic                       hit;

   wreg_addr_dec #(
      .NUM_REGS (NUM_REGS),
      .BYTES    (BYTES),
      .REG_W    (REG_W),
      .LANE_W   (LANE_W)
   ) u_dec (
      .addr    (bus_addr),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .wr_lane (wr_lane),
      .rd_lane (rd_lane),
      .hit     (hit)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
      wreg_coherent #(
         .DATA_W (DATA_W),
         .BYTES  (BYTES)
      ) u_word (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_lane   (wr_lane[r*BYTES +: BYTES]),
         .rd_lane   (rd_lane[r*BYTES +: BYTES]),
         .wdata     (bus_wdata),
         .int_load  (upd_load[r]),
         .int_value (upd_value[r*WORD_W +: WORD_W]),
         .live      (live_word[r*WORD_W +: WORD_W]),
         .rd_byte   (rd_bytes[r*DATA_W +: DATA_W])
      );
   end

   wreg_rd_mux #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W)
   ) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (bus_rd),
      .rd_bytes (rd_bytes),
      .rdata    (bus_rdata)
   );

   assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit) |=> bus_rdata == '0);

   assert_unmapped_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit && upd_load == '0) |=> $stable(live_word));

   assert_single_write_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> $onehot0(wr_lane));

endmodule

// File: tb/wreg_byte_port_tb_top.sv
module wreg_byte_port_tb_top;

   localparam int NR = 2;
   localparam int WW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic [NR-1:0] upd_load = '0;
   logic [NR*WW-1:0] upd_value = '0;
   logic [NR*WW-1:0] live_word;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model
   logic [23:0] m_live [NR];
   logic [15:0] m_hold [NR];
   logic [15:0] m_cap  [NR];

   always #2 clk = ~clk;

   wreg_byte_port dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .upd_load  (upd_load),
      .upd_value (upd_value),
      .live_word (live_word)
   );

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_lives(input string req);
      for (int r = 0; r < NR; r++) check(req, live_word[r*WW +: WW], m_live[r]);
   endtask

   // host write: strobe across one rising edge, results sampled on next falling edge
   task automatic wr_byte(input int r, input int lane, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'(r*4 + lane); bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      if (r < NR) begin
         if (lane == 0) m_live[r] = {m_hold[r], d};
         else if (lane == 1) m_hold[r][7:0] = d;
         else if (lane == 2) m_hold[r][15:8] = d;
      end
   endtask

   task automatic rd_byte(input int r, input int lane, output logic [7:0] q);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 3'(r*4 + lane);
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      q = bus_rdata;
      if (r < NR && lane == 0) m_cap[r] = m_live[r][23:8];
   endtask

   task automatic upd(input int r, input logic [23:0] v);
      @(negedge clk);
      upd_load[r] = 1'b1; upd_value[r*WW +: WW] = v;
      @(posedge clk);
      @(negedge clk);
      upd_load = '0;
      m_live[r] = v;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] q;
      for (int r = 0; r < NR; r++) begin m_live[r] = '0; m_hold[r] = '0; m_cap[r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_lives("R1");
      check("R1 rdata", {16'h0, bus_rdata}, 24'h0);

      // R8 upper reads before any low read return zero
      rd_byte(1, 1, q); check("R8", {16'h0, q}, 24'h0);
      rd_byte(0, 2, q); check("R8", {16'h0, q}, 24'h0);
      // R1 holds are zero: committing only the low byte gives {0,0,byte}
      wr_byte(1, 0, 8'h5A); check_lives("R1 R3");

      // R2/R3 sweep of host writes on both registers
      for (int i = 0; i < 16; i++) begin
         for (int r = 0; r < NR; r++) begin
            logic [23:0] v;
            v = 24'(((i + 1) * 24'h1F3A7) ^ (r * 24'hA5C300));
            wr_byte(r, 2, v[23:16]); check_lives("R2 msb");
            wr_byte(r, 1, v[15:8]);  check_lives("R2 mid");
            wr_byte(r, 0, v[7:0]);
            check("R3", live_word[r*WW +: WW], v);
            check_lives("R9");
         end
      end

      // R3 holds persist: a second low write reuses them
      wr_byte(0, 0, 8'hC3); check_lives("R3 reuse");

      // R9 independent holds: write reg0 upper, commit reg1 low only
      wr_byte(0, 2, 8'h11); wr_byte(0, 1, 8'h22);
      wr_byte(1, 0, 8'h33); check_lives("R9 hold");

      // R5 internal loads and R6/R7 coherent reads
      for (int i = 0; i < 8; i++) begin
         for (int r = 0; r < NR; r++) begin
            logic [23:0] x, y;
            x = 24'((i + 3) * 24'h2D95B1 + r);
            y = ~x;
            upd(r, x); check("R5", live_word[r*WW +: WW], x);
            rd_byte(r, 0, q); check("R6", {16'h0, q}, {16'h0, x[7:0]});
            upd(r, y);
            rd_byte(r, 1, q); check("R7 mid", {16'h0, q}, {16'h0, x[15:8]});
            rd_byte(r, 2, q); check("R7 msb", {16'h0, q}, {16'h0, x[23:16]});
            check_lives("R9 reads");
         end
      end

      // R6 internal load on the same edge as a low read: old word is seen
      upd(0, 24'h123456);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 3'd0;
      upd_load[0] = 1'b1; upd_value[0 +: WW] = 24'hABCDEF;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0; upd_load = '0;
      check("R6 race low", {16'h0, bus_rdata}, 24'h000056);
      m_live[0] = 24'hABCDEF;
      rd_byte(0, 1, q); check("R6 race mid", {16'h0, q}, 24'h000034);
      rd_byte(0, 2, q); check("R6 race msb", {16'h0, q}, 24'h000012);

      // R4 host commit beats internal load on the same edge
      wr_byte(1, 2, 8'h9E); wr_byte(1, 1, 8'h71);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h08;
      upd_load[1] = 1'b1; upd_value[WW +: WW] = 24'h555555;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; upd_load = '0;
      check("R4", live_word[WW +: WW], 24'h9E7108);
      m_live[1] = 24'h9E7108;

      // R10 unmapped lane 3 and R11 hold
      rd_byte(0, 0, q);
      rd_byte(0, 3, q); check("R10 rd", {16'h0, q}, 24'h0);
      repeat (3) @(negedge clk);
      check("R11", {16'h0, bus_rdata}, 24'h0);
      rd_byte(1, 0, q); check("R6 reg1", {16'h0, q}, 24'h000008);
      repeat (2) @(negedge clk);
      check("R11 held", {16'h0, bus_rdata}, 24'h000008);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 8'hFF;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
      check_lives("R10 wr");
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 8'hEE;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
      check_lives("R10 wr7");
      rd_byte(1, 3, q); check("R10 rd7", {16'h0, q}, 24'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule